// File: doc/BRIEF.md
# PHY trim and configuration sequencer

This block brings up a high-speed USB PHY over a small register bus once a start pulse arrives. At start it samples three analog trim codes (termination resistance, time select and drive current) together with a flag that says whether trim data is present at all. From these it builds the first configuration word out of a fixed default. When the trim set is usable, the three trim fields are patched in. When it is not, the trim fields stay at their defaults and the disconnect-threshold field is forced to its maximum.

The block writes the first configuration word to offset 0x0 and the second to offset 0x4. It then works through a short table of indirect PHY parameter writes. Each table entry is driven through the register at offset 0x4 as four strobe steps, and each step is a read of that register followed by a modified write-back. A one-cycle completion pulse closes the sequence. The bus master holds a request until the slave returns ready, so slaves with any latency are supported.

Top module: `phy_cfg_seq`

## Requirements
- R1: After reset, and while idle, the block raises no bus request and holds busy and done low.
- R2: If trim_ok is high and at least one trim code is nonzero, the word written to offset 0x0 is 0x92316680 with bits 31:28 replaced by trim_drv, bits 15:12 by trim_tsel and bits 7:6 by trim_term.
- R3: If trim_ok is low, or all three trim codes are zero, the word written to offset 0x0 is 0x9E316680: the default with bits 27:26 forced to 3 and the trim fields left unchanged.
- R4: The first write goes to offset 0x0. The second write goes to offset 0x4 with data 0x00000106. Every later access uses offset 0x4, and offset 0x0 is never read.
- R5: Each table entry takes four read-then-write pairs on offset 0x4. The writes are: the read value with bits 27:16 set to the 12-bit register number and bit 28 set; then bit 28 cleared; then the data byte merged into bits 23:16 with bit 29 set; then bit 29 cleared.
- R6: The data byte is (value << lsb) masked to bits msb:lsb. In the data step only those field bits within 23:16 are cleared before the byte is ORed in.
- R7: The default table writes value 1, in this order, to: register 0 bit 5; register 1 bits 1:0; register 10 bit 6; register 10 bit 5.
- R8: A build with zero table entries performs only the two configuration writes and then signals done.
- R9: While a request waits for ready, request, write enable, address and write data do not change.
- R10: busy is high from the cycle after start until the last access completes. done then pulses high for exactly one cycle, with busy already low.
- R11: A start pulse while busy is ignored. The running sequence keeps its sampled trim codes, and no new sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence when idle |
| trim_ok | input | 1 | Trim codes were obtained |
| trim_term | input | 2 | Termination resistance trim code |
| trim_tsel | input | 4 | Time select trim code |
| trim_drv | input | 4 | Drive current trim code |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus access request, held until ready |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte offset of the access |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_ready | input | 1 | Slave completes the current access |

## Verification
The hardest situations to reach from the ports are a start pulse that lands in the middle of a running sequence and a reset that arrives while the bus slave is still holding off ready. The bench reaches them with a bus slave model whose ready latency can be set from 0 to 3 cycles. It pulses start a few cycles into a run, using different trim codes, and it drops reset part-way through a run before starting again. The register model in the slave makes every read-modify-write step depend on the previous one, so any wrong ordering shows up in the logged write data.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
    localparam int WORD_W      = 32;
    localparam int TERM_W      = 2;
    localparam int TSEL_W      = 4;
    localparam int DRV_W       = 4;
    localparam int DISC_W      = 2;
    localparam int REGNO_W     = 12;
    localparam int POS_W       = 3;
    localparam int VAL_W       = 8;
    localparam int MAX_ENTRIES = 4;

    // Field positions inside the two configuration words
    localparam int DRV_LSB   = 28;
    localparam int DISC_LSB  = 26;
    localparam int TSEL_LSB  = 12;
    localparam int TERM_LSB  = 6;
    localparam int IADR_LSB  = 16;
    localparam int IDAT_LSB  = 16;
    localparam int ADR_STB   = 28;
    localparam int DAT_STB   = 29;

    typedef struct packed {
        logic [REGNO_W-1:0] reg_no;
        logic [POS_W-1:0]   msb;
        logic [POS_W-1:0]   lsb;
        logic [VAL_W-1:0]   value;
    } pentry_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CFG0 = 3'd1,
        ST_CFG1 = 3'd2,
        ST_RD   = 3'd3,
        ST_WR   = 3'd4
    } seq_state_t;

    function automatic pentry_t default_entry(input int idx);
        pentry_t e;
        case (idx)
            0:       e = '{reg_no: 12'd0,  msb: 3'd5, lsb: 3'd5, value: 8'd1};
            1:       e = '{reg_no: 12'd1,  msb: 3'd1, lsb: 3'd0, value: 8'd1};
            2:       e = '{reg_no: 12'd10, msb: 3'd6, lsb: 3'd6, value: 8'd1};
            default: e = '{reg_no: 12'd10, msb: 3'd5, lsb: 3'd5, value: 8'd1};
        endcase
        return e;
    endfunction

    function automatic logic [VAL_W-1:0] field_mask(input logic [POS_W-1:0] msb,
                                                    input logic [POS_W-1:0] lsb);
        return (8'hFF << lsb) & (8'hFF >> (3'd7 - msb));
    endfunction
endpackage

// File: rtl/phy_trim_word.sv
module phy_trim_word
    import phy_seq_pkg::*;
#(
    parameter logic [WORD_W-1:0] CFG0_DEFAULT = 32'h92316680
) (
    input  logic              trim_ok,
    input  logic [TERM_W-1:0] trim_term,
    input  logic [TSEL_W-1:0] trim_tsel,
    input  logic [DRV_W-1:0]  trim_drv,
    output logic [WORD_W-1:0] word
);
    logic usable;

    always_comb begin
        usable = trim_ok && ((trim_term != '0) || (trim_tsel != '0) || (trim_drv != '0));
        word   = CFG0_DEFAULT;
        if (usable) begin
            word[DRV_LSB  +: DRV_W]  = trim_drv;
            word[TSEL_LSB +: TSEL_W] = trim_tsel;
            word[TERM_LSB +: TERM_W] = trim_term;
        end else begin
            word[DISC_LSB +: DISC_W] = '1;
        end
    end
endmodule

// File: rtl/phy_param_rom.sv
module phy_param_rom
    import phy_seq_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] idx,
    output pentry_t          entry
);
    localparam int SLOTS = 1 << IDX_W;

    pentry_t tbl [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign tbl[g] = default_entry(g);
    end

    assign entry = tbl[idx];
endmodule

// File: rtl/phy_step_merge.sv
module phy_step_merge
    import phy_seq_pkg::*;
(
    input  logic [1:0]        step,
    input  pentry_t           entry,
    input  logic [WORD_W-1:0] cur,
    output logic [WORD_W-1:0] nxt
);
    logic [VAL_W-1:0] mask;
    logic [VAL_W-1:0] dbyte;

    always_comb begin
        mask  = field_mask(entry.msb, entry.lsb);
        dbyte = mask & (entry.value << entry.lsb);
        nxt   = cur;
        case (step)
            2'd0: begin
                nxt[IADR_LSB +: REGNO_W] = entry.reg_no;
                nxt[ADR_STB]             = 1'b1;
            end
            2'd1: nxt[ADR_STB] = 1'b0;
            2'd2: begin
                nxt[IDAT_LSB +: VAL_W] = (cur[IDAT_LSB +: VAL_W] & ~mask) | dbyte;
                nxt[DAT_STB]           = 1'b1;
            end
            default: nxt[DAT_STB] = 1'b0;
        endcase
    end
endmodule

// File: rtl/phy_cfg_seq.sv
module phy_cfg_seq
    import phy_seq_pkg::*;
#(
    parameter int                ADDR_W       = 8,
    parameter int                NUM_PARAMS   = 4,
    parameter logic [WORD_W-1:0] CFG0_DEFAULT = 32'h92316680,
    parameter logic [WORD_W-1:0] CFG1_DEFAULT = 32'h00000106,
    parameter int                OFS_CFG0     = 0,
    parameter int                OFS_CFG1     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              trim_ok,
    input  logic [TERM_W-1:0] trim_term,
    input  logic [TSEL_W-1:0] trim_tsel,
    input  logic [DRV_W-1:0]  trim_drv,
    output logic              busy,
    output logic              done,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic              bus_ready
);
    localparam int             TBL_N    = (NUM_PARAMS > 0) ? NUM_PARAMS : 1;
    localparam int             IDX_W    = (TBL_N > 1) ? $clog2(TBL_N) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TBL_N - 1);
    localparam bit             HAS_TBL  = (NUM_PARAMS > 0);

    typedef struct packed {
        seq_state_t        st;
        logic [IDX_W-1:0]  idx;
        logic [1:0]        step;
        logic [WORD_W-1:0] cfg0;
        logic [WORD_W-1:0] rd;
        logic              done;
    } seq_regs_t;

    seq_regs_t         r_d, r_q;
    logic [WORD_W-1:0] cfg0_new;
    logic [WORD_W-1:0] step_word;
    pentry_t           ent;

    phy_trim_word #(.CFG0_DEFAULT(CFG0_DEFAULT)) u_word (
        .trim_ok   (trim_ok),
        .trim_term (trim_term),
        .trim_tsel (trim_tsel),
        .trim_drv  (trim_drv),
        .word      (cfg0_new)
    );

    phy_param_rom #(.IDX_W(IDX_W)) u_rom (
        .idx   (r_q.idx),
        .entry (ent)
    );

    phy_step_merge u_merge (
        .step  (r_q.step),
        .entry (ent),
        .cur   (r_q.rd),
        .nxt   (step_word)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.cfg0 = cfg0_new;
                    r_d.st   = ST_CFG0;
                end
            end
            ST_CFG0: begin
                if (bus_ready) r_d.st = ST_CFG1;
            end
            ST_CFG1: begin
                if (bus_ready) begin
                    if (HAS_TBL) begin
                        r_d.st   = ST_RD;
                        r_d.idx  = '0;
                        r_d.step = 2'd0;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end
                end
            end
            ST_RD: begin
                if (bus_ready) begin
                    r_d.rd = bus_rdata;
                    r_d.st = ST_WR;
                end
            end
            ST_WR: begin
                if (bus_ready) begin
                    if (r_q.step == 2'd3) begin
                        if (r_q.idx == LAST_IDX) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.idx  = r_q.idx + 1'b1;
                            r_d.step = 2'd0;
                            r_d.st   = ST_RD;
                        end
                    end else begin
                        r_d.step = r_q.step + 2'd1;
                        r_d.st   = ST_RD;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_req  = (r_q.st != ST_IDLE);
        bus_we   = (r_q.st != ST_RD);
        bus_addr = (r_q.st == ST_CFG0) ? ADDR_W'(OFS_CFG0) : ADDR_W'(OFS_CFG1);
        case (r_q.st)
            ST_CFG0: bus_wdata = r_q.cfg0;
            ST_CFG1: bus_wdata = CFG1_DEFAULT;
            ST_WR:   bus_wdata = step_word;
            default: bus_wdata = '0;
        endcase
    end

    assign busy = (r_q.st != ST_IDLE);
    assign done = r_q.done;
endmodule

// File: rtl/phy_cfg_seq_chk.sv
module phy_cfg_seq_chk #(
    parameter int ADDR_W   = 8,
    parameter int OFS_CFG0 = 0,
    parameter int OFS_CFG1 = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_ready
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    assert_addr_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr == ADDR_W'(OFS_CFG0)) || (bus_addr == ADDR_W'(OFS_CFG1)));

    assert_cfg0_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr == ADDR_W'(OFS_CFG0)) |-> bus_we);

    assert_read_then_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready && !bus_we) |=> (bus_req && bus_we && bus_addr == $past(bus_addr)));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

    assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind phy_cfg_seq phy_cfg_seq_chk #(
    .ADDR_W   (ADDR_W),
    .OFS_CFG0 (OFS_CFG0),
    .OFS_CFG1 (OFS_CFG1)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready)
);

// File: tb/sim_phy_cfg_seq.sv
`timescale 1ns/1ps

module sim_bus_model #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lat,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              ready
);
    logic [31:0] reg0 = 32'h0;
    logic [31:0] reg4 = 32'hDEADBEEF;
    logic [1:0]  cnt;
    logic [ADDR_W-1:0] log_addr [256];
    logic [31:0] log_data [256];
    int          log_n = 0;
    int          rd_n  = 0;
    int          rd0_n = 0;

    initial rdata = 32'h0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready <= 1'b0;
            cnt   <= 2'd0;
        end else if (req && !ready) begin
            if (cnt >= lat) begin
                ready <= 1'b1;
                cnt   <= 2'd0;
                if (we) begin
                    if (addr == ADDR_W'(0)) reg0 <= wdata;
                    else                    reg4 <= wdata;
                    log_addr[log_n % 256] <= addr;
                    log_data[log_n % 256] <= wdata;
                    log_n <= log_n + 1;
                end else begin
                    rdata <= (addr == ADDR_W'(0)) ? reg0 : reg4;
                    rd_n  <= rd_n + 1;
                    if (addr == ADDR_W'(0)) rd0_n <= rd0_n + 1;
                end
            end else begin
                cnt <= cnt + 2'd1;
            end
        end else begin
            ready <= 1'b0;
        end
    end
endmodule

module sim_phy_cfg_seq;
    localparam int ADDR_W = 8;

    typedef struct packed {
        logic        ok;
        logic [1:0]  term;
        logic [3:0]  tsel;
        logic [3:0]  drv;
        logic [1:0]  lat;
        logic [31:0] cfg0;
    } vec_t;

    // Expected first word per trim set (R2 valid patches, R3 fallback 0x9E316680)
    localparam vec_t VECS [6] = '{
        '{1'b1, 2'd1, 4'd5, 4'd3, 2'd0, 32'h32315640},
        '{1'b1, 2'd0, 4'd0, 4'd0, 2'd1, 32'h9E316680},
        '{1'b0, 2'd3, 4'hF, 4'hF, 2'd2, 32'h9E316680},
        '{1'b1, 2'd0, 4'd0, 4'd1, 2'd3, 32'h12310600},
        '{1'b1, 2'd2, 4'd0, 4'd0, 2'd1, 32'h02310680},
        '{1'b1, 2'd3, 4'hF, 4'hF, 2'd0, 32'hF231F6C0}
    };

    // Expected write data of the indirect phase for the default table (R5, R6, R7)
    localparam logic [31:0] EXP_P [16] = '{
        32'h10000106, 32'h00000106, 32'h20200106, 32'h00200106,
        32'h10010106, 32'h00010106, 32'h20010106, 32'h00010106,
        32'h100A0106, 32'h000A0106, 32'h204A0106, 32'h004A0106,
        32'h100A0106, 32'h000A0106, 32'h202A0106, 32'h002A0106
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic trim_ok = 1'b0;
    logic [1:0] trim_term = '0;
    logic [3:0] trim_tsel = '0;
    logic [3:0] trim_drv = '0;
    logic [1:0] lat = '0;

    logic busy0, done0, req0, we0, rdy0;
    logic [ADDR_W-1:0] addr0;
    logic [31:0] wd0, rd0;
    logic busy1, done1, req1, we1, rdy1;
    logic [ADDR_W-1:0] addr1;
    logic [31:0] wd1, rd1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    phy_cfg_seq #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .trim_ok(trim_ok),
        .trim_term(trim_term), .trim_tsel(trim_tsel), .trim_drv(trim_drv),
        .busy(busy0), .done(done0), .bus_req(req0), .bus_we(we0),
        .bus_addr(addr0), .bus_wdata(wd0), .bus_rdata(rd0), .bus_ready(rdy0)
    );
    sim_bus_model #(.ADDR_W(ADDR_W)) u_bm0 (
        .clk(clk), .rst_n(rst_n), .lat(lat), .req(req0), .we(we0),
        .addr(addr0), .wdata(wd0), .rdata(rd0), .ready(rdy0)
    );

    phy_cfg_seq #(.ADDR_W(ADDR_W), .NUM_PARAMS(0)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .trim_ok(trim_ok),
        .trim_term(trim_term), .trim_tsel(trim_tsel), .trim_drv(trim_drv),
        .busy(busy1), .done(done1), .bus_req(req1), .bus_we(we1),
        .bus_addr(addr1), .bus_wdata(wd1), .bus_rdata(rd1), .bus_ready(rdy1)
    );
    sim_bus_model #(.ADDR_W(ADDR_W)) u_bm1 (
        .clk(clk), .rst_n(rst_n), .lat(lat), .req(req1), .we(we1),
        .addr(addr1), .wdata(wd1), .rdata(rd1), .ready(rdy1)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic kick(input vec_t v);
        @(negedge clk);
        trim_ok = v.ok; trim_term = v.term; trim_tsel = v.tsel; trim_drv = v.drv;
        lat = v.lat;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 busy after start", 32'(busy0), 32'd1);
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 3000) check("R10 done timeout", 32'd0, 32'd1);
        check("R10 busy low with done", 32'(busy0), 32'd0);
        @(negedge clk);
        check("R10 done one cycle", 32'(done0), 32'd0);
    endtask

    task automatic check_log(input int n0, input int r0, input logic [31:0] cfg0);
        check("R4 access count", 32'(u_bm0.log_n - n0), 32'd18);
        check("R5 read count", 32'(u_bm0.rd_n - r0), 32'd16);
        check("R4 first addr", 32'(u_bm0.log_addr[n0 % 256]), 32'd0);
        check("R2/R3 first word", u_bm0.log_data[n0 % 256], cfg0);
        check("R4 second addr", 32'(u_bm0.log_addr[(n0 + 1) % 256]), 32'd4);
        check("R4 second word", u_bm0.log_data[(n0 + 1) % 256], 32'h00000106);
        for (int k = 0; k < 16; k++) begin
            check("R5 step addr", 32'(u_bm0.log_addr[(n0 + 2 + k) % 256]), 32'd4);
            check("R6/R7 step data", u_bm0.log_data[(n0 + 2 + k) % 256], EXP_P[k]);
        end
        check("R4 no read of offset 0", 32'(u_bm0.rd0_n), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n0, r0, m0;
        vec_t va, vb;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 req in reset", 32'(req0), 32'd0);
        check("R1 busy in reset", 32'(busy0), 32'd0);
        check("R1 done in reset", 32'(done0), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle req", 32'(req0), 32'd0);

        // Vector table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int v = 0; v < 6; v++) begin
            n0 = u_bm0.log_n;
            r0 = u_bm0.rd_n;
            m0 = u_bm1.log_n;
            kick(VECS[v]);
            wait_done();
            check_log(n0, r0, VECS[v].cfg0);
            check("R8 zero-table write count", 32'(u_bm1.log_n - m0), 32'd2);
            check("R8 zero-table first word", u_bm1.log_data[m0 % 256], VECS[v].cfg0);
            check("R8 zero-table idle", 32'(busy1), 32'd0);
        end

        // R11: start during busy is ignored
        va = VECS[0];
        vb = VECS[5];
        va.lat = 2'd2;
        n0 = u_bm0.log_n;
        r0 = u_bm0.rd_n;
        kick(va);
        repeat (4) @(negedge clk);
        trim_ok = vb.ok; trim_term = vb.term; trim_tsel = vb.tsel; trim_drv = vb.drv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_log(n0, r0, va.cfg0);
        n0 = u_bm0.log_n;
        repeat (12) @(negedge clk);
        check("R11 no restart writes", 32'(u_bm0.log_n - n0), 32'd0);
        check("R11 stays idle", 32'(busy0), 32'd0);

        // R1: reset in the middle of a sequence, then a clean rerun
        va = VECS[3];
        kick(va);
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 req after mid reset", 32'(req0), 32'd0);
        check("R1 busy after mid reset", 32'(busy0), 32'd0);
        check("R1 done after mid reset", 32'(done0), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        n0 = u_bm0.log_n;
        r0 = u_bm0.rd_n;
        kick(VECS[4]);
        wait_done();
        check_log(n0, r0, VECS[4].cfg0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule